// File: doc/BRIEF.md
# Burst Word-Address Sequencer

This block produces the word address that a synchronous memory array controller uses during a four-beat burst. When the cycle controller signals the start of a burst, the block captures the full external address. The two low bits become the starting offset inside an aligned four-word block. The upper bits are held for the whole burst. Each later advance strobe moves the low two bits to the next beat. When neither strobe is present, the address stays where it is, which is how a suspended burst behaves.

Two beat orders are supported, and a static order-select input picks between them. Linear order counts upward from the starting offset and wraps inside the four-word block. Interleaved order XORs the starting offset with an internal beat count that runs 0, 1, 2, 3. Board logic is expected to tie the order-select input high when it is left unconnected, so interleaved order is the safe default. The cycle controller decodes all bus cycles and drives the load and advance strobes. The address is registered, so a strobe at one rising edge is visible on the output after that edge.

Top module: `burst_addr_seq`

## Requirements
- R1: After a clock edge with rst_n low, word_addr_o is all zeros.
- R2: After an edge with load_i high, word_addr_o equals the value addr_i had at that edge, in both orders.
- R3: With order_sel_i low (linear), each edge with adv_i high and load_i low sets the low two bits of word_addr_o to their previous value plus one, modulo 4.
- R4: With order_sel_i high (interleaved), after the n-th advance of a burst (n = 0..3), the low two bits equal the starting offset XOR (n mod 4).
- R5: In either order, four advances after a load bring the low two bits back to the starting offset.
- R6: The upper bits word_addr_o[UPPER_W+1:2] change only at an edge where load_i is high.
- R7: At an edge with load_i and adv_i both low, word_addr_o keeps its value, provided order_sel_i is steady.
- R8: When load_i and adv_i are both high at the same edge, the load wins. The output becomes addr_i and no step is applied.
- R9: Bit 0 of word_addr_o toggles on every interleaved advance, because the beat-count step always XORs in an odd value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| order_sel_i | input | 1 | Beat order: 0 linear, 1 interleaved (static) |
| load_i | input | 1 | Burst start: capture addr_i |
| adv_i | input | 1 | Step to the next beat |
| addr_i | input | UPPER_W+2 | External word address |
| word_addr_o | output | UPPER_W+2 | Current burst word address |

## Verification
The bench builds the block with UPPER_W set to 5, so the address is 7 bits wide. With that width, random upper fields often differ from one burst to the next, and a wrong capture or a stray update of the upper bits shows up on the output. Directed sweeps cover all four starting offsets in both orders, with a suspend cycle inside each sweep and a fifth advance that checks the wrap. Random bursts then mix suspends, changes of order between bursts, and loads that collide with advances.

// File: rtl/burst_seq_pkg.sv
// Package: shared widths, types and the beat-offset mapping for the burst
// word-address sequencer. Assumes a fixed four-beat burst window.
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;

    // Maps a start offset and a beat count to the offset presented on the bus.
    function automatic beat_t map_offset(input beat_t start, input beat_t beat, input order_e ord);
        if (ord == ORDER_INTERLEAVE) begin
            return start ^ beat;
        end
        return beat_t'(start + beat);
    endfunction

endpackage

// File: rtl/burst_beat_counter.sv
// Module: burst_beat_counter
// Counts beats within a burst. Load clears the count and has priority over
// advance. With neither strobe the count holds (burst suspend).
// Assumes a synchronous active-low reset.
module burst_beat_counter
    import burst_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  logic  adv_i,
    output beat_t beat_o
);

    beat_t beat_q;

    // Beat count register: clear on load, increment on advance, wraps mod 4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (load_i) begin
            beat_q <= '0;
        end else if (adv_i) begin
            beat_q <= beat_q + beat_t'(1);
        end
    end

    assign beat_o = beat_q;

endmodule

// File: rtl/burst_addr_capture.sv
// Module: burst_addr_capture
// Captures the external address at burst start. Holds the start offset
// and the upper (block) address constant for the rest of the burst.
// Assumes synchronous active-low reset; UPPER_W >= 1.
module burst_addr_capture
    import burst_seq_pkg::*;
#(
    parameter int UPPER_W = 16,
    localparam int ADDR_W = UPPER_W + BEAT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [UPPER_W-1:0] upper_o,
    output beat_t              start_o
);

    logic [UPPER_W-1:0] upper_q;
    beat_t              start_q;

    // Address capture register: loads only on a burst-start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
        end else if (load_i) begin
            upper_q <= addr_i[ADDR_W-1:BEAT_W];
            start_q <= addr_i[BEAT_W-1:0];
        end
    end

    assign upper_o = upper_q;
    assign start_o = start_q;

endmodule

// File: rtl/burst_offset_map.sv
// Module: burst_offset_map
// Combinational mapping of start offset and beat count to the low address
// bits, linear (add, wrap mod 4) or interleaved (XOR). Assumes the order
// select is static during a burst.
module burst_offset_map
    import burst_seq_pkg::*;
(
    input  beat_t start_i,
    input  beat_t beat_i,
    input  logic  order_sel_i,
    output beat_t offset_o
);

    order_e ord;

    // Decode the order select into the order type.
    always_comb begin
        ord = order_sel_i ? ORDER_INTERLEAVE : ORDER_LINEAR;
    end

    // Produce the presented offset for the current beat.
    always_comb begin
        offset_o = map_offset(start_i, beat_i, ord);
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Burst word-address sequencer: captures the address on load, steps the low
// two bits on advance in linear or interleaved order, holds otherwise.
// Assumes load/advance strobes come from an external cycle decoder and that
// order_sel_i is tied high when unconnected. Synchronous active-low reset.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int UPPER_W = 16,
    localparam int ADDR_W = UPPER_W + BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              order_sel_i,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] word_addr_o
);

    logic [UPPER_W-1:0] upper;
    beat_t              start;
    beat_t              beat;
    beat_t              offset;

    burst_addr_capture #(.UPPER_W(UPPER_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .addr_i  (addr_i),
        .upper_o (upper),
        .start_o (start)
    );

    burst_beat_counter u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .adv_i  (adv_i),
        .beat_o (beat)
    );

    burst_offset_map u_map (
        .start_i     (start),
        .beat_i      (beat),
        .order_sel_i (order_sel_i),
        .offset_o    (offset)
    );

    // Assemble the full word address from block and beat offset.
    always_comb begin
        word_addr_o = {upper, offset};
    end

endmodule

// File: rtl/burst_addr_seq_chk.sv
// Module: burst_addr_seq_chk
// Checker with temporal properties at the ports of burst_addr_seq.
// Bound to every instance of the top module.
module burst_addr_seq_chk #(
    parameter int UPPER_W = 16,
    localparam int ADDR_W = UPPER_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              order_sel_i,
    input logic              load_i,
    input logic              adv_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] word_addr_o
);

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> word_addr_o == $past(addr_i));

    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_i && !order_sel_i) |=>
            (order_sel_i || word_addr_o[1:0] == $past(word_addr_o[1:0]) + 2'd1));

    assert_upper_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(word_addr_o[ADDR_W-1:2]));

    assert_suspend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> (!$stable(order_sel_i) || $stable(word_addr_o)));

    assert_interleave_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_i && order_sel_i) |=>
            (!order_sel_i || word_addr_o[0] != $past(word_addr_o[0])));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.UPPER_W(UPPER_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .order_sel_i (order_sel_i),
    .load_i      (load_i),
    .adv_i       (adv_i),
    .addr_i      (addr_i),
    .word_addr_o (word_addr_o)
);

// File: tb/burst_addr_seq_test.sv
// Bench for burst_addr_seq: directed sweeps plus seeded random bursts,
// compared against a reference model built from the requirements.
module burst_addr_seq_test;

    localparam int UW = 5;
    localparam int AW = UW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          order_sel_i = 1'b1;
    logic          load_i = 1'b0;
    logic          adv_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] word_addr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [1:0]    m_start = '0;
    logic [1:0]    m_beat  = '0;
    logic [UW-1:0] m_upper = '0;

    always #5 clk = ~clk;

    burst_addr_seq #(.UPPER_W(UW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .order_sel_i (order_sel_i),
        .load_i      (load_i),
        .adv_i       (adv_i),
        .addr_i      (addr_i),
        .word_addr_o (word_addr_o)
    );

    // Expected word address from the reference state.
    function automatic logic [AW-1:0] expect_addr(input logic ord);
        logic [1:0] off;
        off = ord ? (m_start ^ m_beat) : (m_start + m_beat);
        return {m_upper, off};
    endfunction

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model at posedge, sample 2 ns later.
    task automatic step(input logic ld, input logic ad, input logic [AW-1:0] a);
        string tag;
        load_i = ld;
        adv_i  = ad;
        addr_i = a;
        @(posedge clk);
        if (ld) begin
            m_start = a[1:0];
            m_beat  = 2'd0;
            m_upper = a[AW-1:2];
            tag = ad ? "R8" : "R2";
        end else if (ad) begin
            m_beat = m_beat + 2'd1;
            tag = order_sel_i ? "R4" : "R3";
        end else begin
            tag = "R7";
        end
        #2;
        check(tag, word_addr_o, expect_addr(order_sel_i));
        checks++;
        if (word_addr_o[AW-1:2] !== m_upper) begin
            fails++;
            $display("FAIL R6 actual=%h expected=%h", word_addr_o[AW-1:2], m_upper);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h1234_5a5a;
        void'($urandom(seed));
        @(negedge clk);
        @(posedge clk);
        #2;
        check("R1", word_addr_o, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed: every start offset in both orders, with a suspend and a wrap.
        for (int md = 0; md < 2; md++) begin
            order_sel_i = md[0];
            for (int s = 0; s < 4; s++) begin
                logic [AW-1:0] a;
                a = {5'b10110 ^ UW'(s * 7), 2'(s)};
                step(1'b1, 1'b0, a);
                step(1'b0, 1'b1, '0);
                step(1'b0, 1'b0, '1);
                step(1'b0, 1'b1, '0);
                step(1'b0, 1'b1, '0);
                step(1'b0, 1'b1, '0);
                check("R5", {word_addr_o[AW-1:2], word_addr_o[1:0]}, a);
                step(1'b0, 1'b1, '0);
            end
        end

        // Directed: load colliding with advance mid-burst.
        order_sel_i = 1'b0;
        step(1'b1, 1'b0, 7'h2d);
        step(1'b0, 1'b1, 7'h00);
        step(1'b1, 1'b1, 7'h46);
        check("R8", word_addr_o, 7'h46);

        // Random bursts with suspends, collisions and order changes.
        for (int b = 0; b < 600; b++) begin
            int len;
            order_sel_i = 1'($urandom % 2);
            step(1'b1, 1'($urandom % 4 == 0), AW'($urandom));
            len = 2 + int'($urandom % 9);
            for (int c = 0; c < len; c++) begin
                logic ld;
                ld = ($urandom % 16 == 0);
                step(ld, 1'($urandom % 10 < 7), AW'($urandom));
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule